// File: doc/BRIEF.md
# Four-bit accumulator execute unit

This block is the data half of a tiny nybble-wide microcontroller. Each cycle in which the sequencer presents an instruction byte, the unit decodes it and updates its working state: a 4-bit accumulator, a 4-bit auxiliary register, a 6-bit data pointer (a 4-bit low part and a 2-bit high part), a carry flag and a 32-word by 4-bit scratch RAM. The opcodes it runs cover immediate and memory arithmetic, loads, stores and exchanges, single-bit set, clear and test, and port reads and writes.

The machine has no conditional jumps. Every test instead arms a one-shot "skip" flag. The instruction that follows an armed flag still uses its cycle, but it changes nothing, and the flag then clears. Opcodes that move the program counter (jumps, calls and returns) are not executed here. The unit classifies them on a small decode output so that an external sequencer can act on them. A return-and-skip also arms the skip flag. The port number for I/O is always the low part of the data pointer.

Top module: `nyb_exec`

## Requirements
- R1: After reset the accumulator, auxiliary register, pointer, carry and skip flag are all zero, and every RAM word reads as zero.
- R2: Opcode 0x00+N sets A to (A+N) mod 16. It arms a skip when A+N exceeds 15 and leaves C unchanged, so 0x00 is a no-op.
- R3: 0x10+N arms a skip when A equals N. 0x20+N loads the low pointer part BL with N, 0x30+N loads A with N, and 0x74+N (N in 0..3) loads the high pointer part BM with N.
- R4: 0x70 sets A to (A+M) mod 16 and keeps C. 0x72 sets A to (A+M+C) mod 16 and writes the carry-out to C. 0x73 does the same as 0x72 and also arms a skip when the carry-out is 1.
- R5: 0x44 replaces A with its two's complement mod 16, and 0x54 replaces A with its bitwise inverse. Neither touches C.
- R6: The RAM word M is selected by {B[4], BL}, so B[5] has no effect on addressing. 0x40 copies M to A, 0x41 swaps A and M, and 0x4A copies A to M.
- R7: 0x42 swaps A and M and then increments BL, arming a skip when BL wraps from 15 to 0. 0x43 swaps A and M and then decrements BL, arming a skip when BL wraps from 0 to 15. 0x52 copies M to A and then increments BL, with the same wrap skip as 0x42.
- R8: For N in 0..3: 0x60+N arms a skip when bit N of M is 1, 0x64+N arms a skip when bit N of A is 1, 0x68+N clears bit N of M, and 0x6C+N sets bit N of M.
- R9: 0x46 raises `port_wr` for one cycle with `port_wdata` equal to A, and 0x47 does the same with data 0. In both cases `port_num` equals BL. 0x55 loads A from `port_rdata`.
- R10: 0x48 sets C and 0x49 clears C. 0x57 swaps A and BL, 0x5C copies A to X, and 0x5D swaps A and X.
- R11: While the skip flag is set, the next presented instruction changes no register, RAM word or port, raises no sequencer code, and clears the flag. Cycles without `instr_valid` leave all state and the flag unchanged.
- R12: `seq_kind` is 1 for 0x78-0x7B, 2 for 0x7C-0x7F, 3 for 0x80-0xFF, 4 for 0x4C and 5 for 0x4D, and 0 otherwise. 0x4D also arms a skip. Undefined opcodes such as 0x45 and 0x5E change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction byte is presented this cycle |
| instr | input | 8 | Instruction byte |
| port_rdata | input | 4 | Data read from the port selected by `port_num` |
| port_num | output | 4 | Selected port number (BL) |
| port_wr | output | 1 | Port write strobe |
| port_wdata | output | 4 | Port write data |
| skip_pending | output | 1 | The next presented instruction will be skipped |
| seq_kind | output | 3 | Sequencer opcode class (see R12) |
| acc_o | output | 4 | Accumulator A |
| x_o | output | 4 | Auxiliary register X |
| b_o | output | 6 | Pointer {BM, BL} |
| carry_o | output | 1 | Carry flag C |

## Verification
The hardest case to reach is a skip that comes from pointer wraparound rather than from a compare. To get there, BL must first be parked at 15 or 0 through the immediate load. An exchange-step then has to wrap it, and the cycle after that must carry an instruction that would have changed visible state had it run. The stimulus walks BL into both wrap edges, follows each wrapping step with an accumulator load, and then repeats the step away from the edge to show that no skip is armed there. Idle cycles are placed while a skip is armed, to show that the flag waits for the next real instruction.

// File: rtl/nyb_pkg.sv
package nyb_pkg;
  localparam int NYB_W = 4;
  localparam int BL_W  = 4;
  localparam int BM_W  = 2;

  typedef logic [NYB_W-1:0] nyb_t;

  typedef enum logic [5:0] {
    OP_NOP, OP_ADI, OP_SKAI, OP_LBLI, OP_LDI, OP_LD, OP_XCH, OP_XI, OP_XD,
    OP_NEGA, OP_OUT, OP_OUT0, OP_SC, OP_RC, OP_ST, OP_RIT, OP_RITSK, OP_LI,
    OP_COMA, OP_IN, OP_XAL, OP_LXA, OP_XAX, OP_SKM, OP_SKA, OP_RM, OP_SM,
    OP_AD, OP_ADC, OP_ADCSK, OP_LBMI, OP_TL, OP_TML, OP_T
  } op_e;

  typedef enum logic [2:0] {
    SEQ_NONE = 3'd0, SEQ_JMPL = 3'd1, SEQ_CALL = 3'd2,
    SEQ_JMPS = 3'd3, SEQ_RET = 3'd4, SEQ_RETSK = 3'd5
  } seq_e;

  typedef struct packed {
    op_e  op;
    nyb_t imm;
  } dec_t;

  // sum with carry-out in the top bit
  function automatic logic [NYB_W:0] add_nyb(nyb_t a, nyb_t b, logic cin);
    return {1'b0, a} + {1'b0, b} + {{NYB_W{1'b0}}, cin};
  endfunction

  // pointer step: {wrapped, next}
  function automatic logic [BL_W:0] step_ptr(logic [BL_W-1:0] v, logic down);
    logic wrap;
    logic [BL_W-1:0] nxt;
    if (down) begin
      wrap = (v == '0);
      nxt  = v - 1'b1;
    end else begin
      wrap = (v == '1);
      nxt  = v + 1'b1;
    end
    return {wrap, nxt};
  endfunction

  function automatic nyb_t neg_nyb(nyb_t a);
    return (~a) + 1'b1;
  endfunction

  function automatic nyb_t bit_mask(logic [1:0] idx);
    return nyb_t'(1) << idx;
  endfunction
endpackage

// File: rtl/nyb_decode.sv
module nyb_decode
  import nyb_pkg::*;
(
  input  logic [7:0] instr,
  output dec_t       dec
);
  always_comb begin
    dec.imm = instr[3:0];
    dec.op  = OP_NOP;
    casez (instr)
      8'b0000_????: dec.op = OP_ADI;
      8'b0001_????: dec.op = OP_SKAI;
      8'b0010_????: dec.op = OP_LBLI;
      8'b0011_????: dec.op = OP_LDI;
      8'h40:        dec.op = OP_LD;
      8'h41:        dec.op = OP_XCH;
      8'h42:        dec.op = OP_XI;
      8'h43:        dec.op = OP_XD;
      8'h44:        dec.op = OP_NEGA;
      8'h46:        dec.op = OP_OUT;
      8'h47:        dec.op = OP_OUT0;
      8'h48:        dec.op = OP_SC;
      8'h49:        dec.op = OP_RC;
      8'h4A:        dec.op = OP_ST;
      8'h4C:        dec.op = OP_RIT;
      8'h4D:        dec.op = OP_RITSK;
      8'h52:        dec.op = OP_LI;
      8'h54:        dec.op = OP_COMA;
      8'h55:        dec.op = OP_IN;
      8'h57:        dec.op = OP_XAL;
      8'h5C:        dec.op = OP_LXA;
      8'h5D:        dec.op = OP_XAX;
      8'b0110_00??: dec.op = OP_SKM;
      8'b0110_01??: dec.op = OP_SKA;
      8'b0110_10??: dec.op = OP_RM;
      8'b0110_11??: dec.op = OP_SM;
      8'h70:        dec.op = OP_AD;
      8'h72:        dec.op = OP_ADC;
      8'h73:        dec.op = OP_ADCSK;
      8'b0111_01??: dec.op = OP_LBMI;
      8'b0111_10??: dec.op = OP_TL;
      8'b0111_11??: dec.op = OP_TML;
      8'b1???_????: dec.op = OP_T;
      default:      dec.op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/nyb_ram.sv
module nyb_ram #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wd;
    end
  end

  assign rd = mem[addr];
endmodule

// File: rtl/nyb_alu.sv
module nyb_alu
  import nyb_pkg::*;
(
  input  dec_t            dec,
  input  nyb_t            a,
  input  nyb_t            x,
  input  logic [BL_W-1:0] bl,
  input  logic [BM_W-1:0] bm,
  input  logic            c,
  input  nyb_t            m,
  input  nyb_t            pin,
  output nyb_t            a_n,
  output nyb_t            x_n,
  output logic [BL_W-1:0] bl_n,
  output logic [BM_W-1:0] bm_n,
  output logic            c_n,
  output logic            m_we,
  output nyb_t            m_wd,
  output logic            skip_n,
  output logic            port_wr,
  output nyb_t            port_wd,
  output seq_e            seq
);
  logic [NYB_W:0] sum;
  logic [BL_W:0]  stp;

  always_comb begin
    a_n = a; x_n = x; bl_n = bl; bm_n = bm; c_n = c;
    m_we = 1'b0; m_wd = m; skip_n = 1'b0;
    port_wr = 1'b0; port_wd = '0; seq = SEQ_NONE;
    sum = '0; stp = '0;
    case (dec.op)
      OP_ADI: begin
        sum = add_nyb(a, dec.imm, 1'b0);
        a_n = sum[NYB_W-1:0];
        skip_n = sum[NYB_W];
      end
      OP_SKAI: skip_n = (a == dec.imm);
      OP_LBLI: bl_n = dec.imm;
      OP_LDI:  a_n = dec.imm;
      OP_LD:   a_n = m;
      OP_XCH: begin
        a_n = m; m_we = 1'b1; m_wd = a;
      end
      OP_XI, OP_XD: begin
        a_n = m; m_we = 1'b1; m_wd = a;
        stp = step_ptr(bl, dec.op == OP_XD);
        bl_n = stp[BL_W-1:0];
        skip_n = stp[BL_W];
      end
      OP_LI: begin
        a_n = m;
        stp = step_ptr(bl, 1'b0);
        bl_n = stp[BL_W-1:0];
        skip_n = stp[BL_W];
      end
      OP_NEGA: a_n = neg_nyb(a);
      OP_COMA: a_n = ~a;
      OP_OUT: begin
        port_wr = 1'b1; port_wd = a;
      end
      OP_OUT0: port_wr = 1'b1;
      OP_SC: c_n = 1'b1;
      OP_RC: c_n = 1'b0;
      OP_ST: begin
        m_we = 1'b1; m_wd = a;
      end
      OP_RIT: seq = SEQ_RET;
      OP_RITSK: begin
        seq = SEQ_RETSK; skip_n = 1'b1;
      end
      OP_IN:  a_n = pin;
      OP_XAL: begin
        a_n = bl; bl_n = a;
      end
      OP_LXA: x_n = a;
      OP_XAX: begin
        a_n = x; x_n = a;
      end
      OP_SKM: skip_n = m[dec.imm[1:0]];
      OP_SKA: skip_n = a[dec.imm[1:0]];
      OP_RM: begin
        m_we = 1'b1; m_wd = m & ~bit_mask(dec.imm[1:0]);
      end
      OP_SM: begin
        m_we = 1'b1; m_wd = m | bit_mask(dec.imm[1:0]);
      end
      OP_AD: begin
        sum = add_nyb(a, m, 1'b0);
        a_n = sum[NYB_W-1:0];
      end
      OP_ADC, OP_ADCSK: begin
        sum = add_nyb(a, m, c);
        a_n = sum[NYB_W-1:0];
        c_n = sum[NYB_W];
        skip_n = (dec.op == OP_ADCSK) && sum[NYB_W];
      end
      OP_LBMI: bm_n = dec.imm[BM_W-1:0];
      OP_TL:   seq = SEQ_JMPL;
      OP_TML:  seq = SEQ_CALL;
      OP_T:    seq = SEQ_JMPS;
      default: ;
    endcase
  end
endmodule

// File: rtl/nyb_exec.sv
module nyb_exec
  import nyb_pkg::*;
#(
  parameter int RAM_AW = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_valid,
  input  logic [7:0] instr,
  input  logic [3:0] port_rdata,
  output logic [3:0] port_num,
  output logic       port_wr,
  output logic [3:0] port_wdata,
  output logic       skip_pending,
  output logic [2:0] seq_kind,
  output logic [3:0] acc_o,
  output logic [3:0] x_o,
  output logic [5:0] b_o,
  output logic       carry_o
);
  localparam int RAM_HI = RAM_AW - BL_W;

  nyb_t            acc, xr;
  logic [BL_W-1:0] bl;
  logic [BM_W-1:0] bm;
  logic            cy, skip_q;

  dec_t            dec;
  nyb_t            a_n, x_n, m_rd, m_wd, p_wd;
  logic [BL_W-1:0] bl_n;
  logic [BM_W-1:0] bm_n;
  logic            c_n, m_we, skip_n, p_wr;
  seq_e            seq;

  // named event: this cycle executes (not idle, not skipped)
  logic exec_now;
  assign exec_now = instr_valid && !skip_q;

  nyb_decode u_dec (.instr(instr), .dec(dec));

  nyb_ram #(.DATA_W(NYB_W), .ADDR_W(RAM_AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(exec_now && m_we),
    .addr({bm[RAM_HI-1:0], bl}), .wd(m_wd), .rd(m_rd)
  );

  nyb_alu u_alu (
    .dec(dec), .a(acc), .x(xr), .bl(bl), .bm(bm), .c(cy), .m(m_rd),
    .pin(port_rdata), .a_n(a_n), .x_n(x_n), .bl_n(bl_n), .bm_n(bm_n),
    .c_n(c_n), .m_we(m_we), .m_wd(m_wd), .skip_n(skip_n),
    .port_wr(p_wr), .port_wd(p_wd), .seq(seq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0; xr <= '0; bl <= '0; bm <= '0; cy <= 1'b0; skip_q <= 1'b0;
    end else if (instr_valid) begin
      if (skip_q) begin
        skip_q <= 1'b0;
      end else begin
        acc <= a_n; xr <= x_n; bl <= bl_n; bm <= bm_n; cy <= c_n;
        skip_q <= skip_n;
      end
    end
  end

  assign port_num     = bl;
  assign port_wr      = exec_now && p_wr;
  assign port_wdata   = p_wd;
  assign skip_pending = skip_q;
  assign seq_kind     = exec_now ? seq : SEQ_NONE;
  assign acc_o        = acc;
  assign x_o          = xr;
  assign b_o          = {bm, bl};
  assign carry_o      = cy;

  // R3: immediate load lands in A
  a_r3_ldi_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_now && instr[7:4] == 4'h3) |=> (acc == $past(instr[3:0])));

  // R11: a skipped slot freezes state and consumes the flag
  a_r11_skip_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && skip_q) |=> (!skip_q && $stable(acc) && $stable(xr)
                                 && $stable(bl) && $stable(bm) && $stable(cy)));

  // R11: idle cycles hold the flag and the accumulator
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid) |=> ($stable(skip_q) && $stable(acc)));

  // R7: incrementing exchange at BL=15 wraps and arms a skip
  a_r7_xi_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_now && instr == 8'h42 && bl == 4'hF) |=> (skip_q && bl == 4'h0));

  // R4: plain add keeps the carry
  a_r4_ad_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_now && instr == 8'h70) |=> $stable(cy));

  // R9: zero output writes zero
  a_r9_out0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && instr == 8'h47) |-> (port_wdata == 4'h0));
endmodule

// File: tb/nyb_exec_test.sv
module nyb_exec_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, instr_valid = 1'b0;
  logic [7:0] instr = 8'h00;
  logic [3:0] port_rdata, port_num, port_wdata, acc_o, x_o;
  logic [5:0] b_o;
  logic [2:0] seq_kind;
  logic       port_wr, skip_pending, carry_o;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign port_rdata = port_num ^ 4'h5;

  nyb_exec uut (.*);

  typedef struct {
    logic [3:0] a, x;
    logic [5:0] b;
    logic       c, sk;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [3:0] ma, mx, mbl;
  logic [1:0] mbm;
  logic       mc, msk;
  logic [3:0] mram [32];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compare registered state one cycle after each driven slot
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(acc_o == e.a, e.tag, "A", acc_o, e.a);
      chk(x_o == e.x, e.tag, "X", x_o, e.x);
      chk(b_o == e.b, e.tag, "B", b_o, e.b);
      chk(carry_o == e.c, e.tag, "C", carry_o, e.c);
      chk(skip_pending == e.sk, e.tag, "skip", skip_pending, e.sk);
    end
  end

  task automatic push(string tag);
    exp_t e;
    e.a = ma; e.x = mx; e.b = {mbm, mbl}; e.c = mc; e.sk = msk; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic issue(input logic [7:0] op, input string tag);
    int t;
    logic [4:0] ad;
    logic [3:0] tmp, ewd, pnum;
    logic ewr, nsk;
    logic [2:0] eseq;
    @(negedge clk);
    instr = op; instr_valid = 1'b1;
    ewr = 0; ewd = 0; eseq = 0; nsk = 0; pnum = mbl;
    if (msk) begin
      msk = 0;
    end else begin
      ad = {mbm[0], mbl};
      casez (op)
        8'b0000_????: begin t = int'(ma) + int'(op[3:0]); ma = t[3:0]; nsk = (t > 15); end
        8'b0001_????: nsk = (ma == op[3:0]);
        8'b0010_????: mbl = op[3:0];
        8'b0011_????: ma = op[3:0];
        8'h40: ma = mram[ad];
        8'h41: begin tmp = mram[ad]; mram[ad] = ma; ma = tmp; end
        8'h42: begin tmp = mram[ad]; mram[ad] = ma; ma = tmp;
                 if (mbl == 15) begin mbl = 0; nsk = 1; end else mbl = mbl + 1; end
        8'h43: begin tmp = mram[ad]; mram[ad] = ma; ma = tmp;
                 if (mbl == 0) begin mbl = 15; nsk = 1; end else mbl = mbl - 1; end
        8'h52: begin ma = mram[ad];
                 if (mbl == 15) begin mbl = 0; nsk = 1; end else mbl = mbl + 1; end
        8'h44: begin t = (16 - int'(ma)) % 16; ma = t[3:0]; end
        8'h54: ma = 4'hF - ma;
        8'h46: begin ewr = 1; ewd = ma; end
        8'h47: begin ewr = 1; ewd = 0; end
        8'h48: mc = 1;
        8'h49: mc = 0;
        8'h4A: mram[ad] = ma;
        8'h4C: eseq = 4;
        8'h4D: begin eseq = 5; nsk = 1; end
        8'h55: ma = mbl ^ 4'h5;
        8'h57: begin tmp = mbl; mbl = ma; ma = tmp; end
        8'h5C: mx = ma;
        8'h5D: begin tmp = mx; mx = ma; ma = tmp; end
        8'b0110_00??: nsk = mram[ad][op[1:0]];
        8'b0110_01??: nsk = ma[op[1:0]];
        8'b0110_10??: mram[ad][op[1:0]] = 1'b0;
        8'b0110_11??: mram[ad][op[1:0]] = 1'b1;
        8'h70: begin t = int'(ma) + int'(mram[ad]); ma = t[3:0]; end
        8'h72, 8'h73: begin
          t = int'(ma) + int'(mram[ad]) + int'(mc);
          ma = t[3:0]; mc = (t > 15);
          if (op == 8'h73) nsk = (t > 15);
        end
        8'b0111_01??: mbm = op[1:0];
        8'b0111_10??: eseq = 1;
        8'b0111_11??: eseq = 2;
        8'b1???_????: eseq = 3;
        default: ;
      endcase
      msk = nsk;
    end
    #1;
    chk(port_wr == ewr, tag, "port_wr", port_wr, ewr);
    if (ewr) begin
      chk(port_wdata == ewd, tag, "port_wdata", port_wdata, ewd);
      chk(port_num == pnum, tag, "port_num", port_num, pnum);
    end
    chk(seq_kind == eseq, tag, "seq_kind", seq_kind, eseq);
    push(tag);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    instr_valid = 1'b0; instr = 8'h48;
    #1;
    chk(port_wr == 1'b0, tag, "idle port_wr", port_wr, 0);
    push(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    ma = 0; mx = 0; mbl = 0; mbm = 0; mc = 0; msk = 0;
    for (int i = 0; i < 32; i++) mram[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(acc_o == 0 && x_o == 0 && b_o == 0 && carry_o == 0 && skip_pending == 0,
        "R1", "reset state", {acc_o, x_o}, 0);
    issue(8'h40, "R1 ram zero");
    // R2 immediate add and overflow skip, R11 skipped slot
    issue(8'h3C, "R3 ldi");
    issue(8'h05, "R2 adi overflow");
    issue(8'h3F, "R11 skipped ldi");
    issue(8'h02, "R2 adi no overflow");
    issue(8'h00, "R2 nop");
    issue(8'h13, "R3 skai equal");
    idle("R11 idle keeps skip");
    idle("R11 idle keeps skip");
    issue(8'h48, "R11 skipped sc");
    issue(8'h14, "R3 skai unequal");
    issue(8'h48, "R10 sc");
    issue(8'h49, "R10 rc");
    // R6 addressing ignores B[5]
    issue(8'h27, "R3 lbli");
    issue(8'h76, "R3 lbmi");
    issue(8'h39, "R3 ldi");
    issue(8'h4A, "R6 store");
    issue(8'h74, "R3 lbmi zero");
    issue(8'h30, "R3 ldi");
    issue(8'h40, "R6 load top bit ignored");
    // R4 adds
    issue(8'h38, "R4 setup");
    issue(8'h70, "R4 ad keeps carry");
    issue(8'h48, "R10 sc");
    issue(8'h72, "R4 adc");
    issue(8'h3F, "R4 setup");
    issue(8'h73, "R4 adcsk overflow");
    issue(8'h3A, "R11 skipped ldi");
    issue(8'h70, "R4 ad after skip");
    // R5
    issue(8'h33, "R5 setup");
    issue(8'h44, "R5 nega");
    issue(8'h54, "R5 coma");
    // R10 register moves
    issue(8'h57, "R10 xal");
    issue(8'h5C, "R10 lxa");
    issue(8'h31, "R10 setup");
    issue(8'h5D, "R10 xax");
    issue(8'h41, "R6 exchange");
    issue(8'h40, "R6 load back");
    // R8 bit operations
    issue(8'h6F, "R8 sm bit3");
    issue(8'h69, "R8 rm bit1");
    issue(8'h61, "R8 skm clear bit");
    issue(8'h60, "R8 skm set bit");
    issue(8'h3E, "R11 skipped ldi");
    issue(8'h40, "R8 load modified word");
    issue(8'h65, "R8 ska clear bit");
    issue(8'h66, "R8 ska set bit");
    issue(8'h37, "R11 skipped ldi");
    // R7 pointer stepping and wrap
    issue(8'h2F, "R7 setup bl15");
    issue(8'h34, "R7 setup");
    issue(8'h42, "R7 xi wrap");
    issue(8'h3B, "R7 skipped after wrap");
    issue(8'h43, "R7 xd wrap");
    issue(8'h3B, "R7 skipped after wrap");
    issue(8'h52, "R7 li wrap");
    issue(8'h3B, "R7 skipped after wrap");
    issue(8'h42, "R7 xi no wrap");
    issue(8'h43, "R7 xd no wrap");
    issue(8'h2F, "R7 setup");
    issue(8'h40, "R7 load stored word");
    // R9 ports
    issue(8'h26, "R9 setup");
    issue(8'h3A, "R9 setup");
    issue(8'h46, "R9 out");
    issue(8'h47, "R9 out0");
    issue(8'h55, "R9 in");
    // R12 sequencer codes
    issue(8'h4C, "R12 return");
    issue(8'h4D, "R12 return skip");
    issue(8'h80, "R12 skipped jump");
    issue(8'h7A, "R12 long jump");
    issue(8'h7D, "R12 call");
    issue(8'h85, "R12 short jump");
    issue(8'h5E, "R12 undefined");
    issue(8'h45, "R12 undefined");
    idle("R12 final");
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule